// File: doc/BRIEF.md
# Mode-Dependent Supervisory Watchdog

This block supervises a host processor on behalf of a system companion chip. Software configures it through one 16-bit control word on a simple register port. It must then service the watchdog by pulsing a trigger input. Time is counted in ticks of a local millisecond oscillator. One mode bit, together with the chip's Normal/Standby state, selects one of three behaviours: Window, Timeout or Off. When the watchdog is missed or serviced at the wrong time, the block issues a reset-request pulse of fixed length. An external disable pin overrides everything: it turns the watchdog off, raises a status flag and requests a one-time software reset.

The controller has five states:
- `ST_OFF` does not supervise.
- `ST_TIMEOUT` counts one full period; a trigger restarts it.
- `ST_CLOSED` is the first half of a window period; a trigger here leads to `ST_RESET`. After half a period it moves to `ST_OPEN`.
- `ST_OPEN` is the second half; a trigger returns to `ST_CLOSED` with the counter cleared. Expiry leads to `ST_RESET`.
- `ST_RESET` drives the request for a fixed number of ticks and then enters the start state of the current mode.

From any state other than `ST_RESET`, two events take priority over the per-state rules:
- A rising edge on the disable pin moves to `ST_RESET`.
- An accepted register write, or a change of the effective mode, restarts the start state of the current mode.

Top module: `wdog_supervisor`

## Requirements
- R1: The 3-bit period code in control bits 10:8 selects the period in ticks: 0→8, 1→16, 2→32, 3→64, 4→128, 5→256, 6→1024, 7→4096.
- R2: After `rst_n` the control word reads 0x0400 (code 4, mode bit 0, lock 0). The period code also returns to 4 at the end of every reset-request pulse.
- R3: The effective mode depends on the mode bit (control bit 11) and the `standby` input:
  - bit 0 in Normal gives Window.
  - bit 0 in Standby gives Timeout.
  - bit 1 in Normal gives Timeout.
  - bit 1 in Standby gives Off.
- R4: In Timeout mode, a trigger clears the count. If P ticks pass without a trigger, `rst_req` rises after the P-th tick.
- R5: In Window mode, a trigger during the first P/2 ticks after a restart raises `rst_req` on the next cycle. So does reaching P ticks without a trigger.
- R6: A trigger in the same cycle as the tick that would expire the period is honoured as a service, and no reset follows.
- R7: A write accepted by the register, or a change of effective mode, restarts the counter from zero in the start state of the current mode.
- R8: `rst_req` stays high for exactly RST_TICKS ticks (default 4) and then falls.
- R9: A rising edge on `wd_off_pin` raises `rst_req` on the next cycle. While the pin stays high:
  - control bit 7 reads 1;
  - no further reset request occurs.
- R10: Writing bit 12 as 1 sets a lock. The lock holds until `rst_n`, and while it is set, writes change nothing.
- R11: A write is accepted only when bits 15:13 are 000. Readback places the lock in bit 12, the mode bit in bit 11, the code in bits 10:8 and the off flag in bit 7; all other bits read zero.
- R12: The counter advances only on cycles with `tick_ms` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle millisecond tick |
| trig | input | 1 | Watchdog service pulse |
| standby | input | 1 | 1 = Standby state, 0 = Normal state |
| wd_off_pin | input | 1 | External watchdog disable, active high |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word readback |
| rst_req | output | 1 | Reset request pulse |

## Verification
The service trigger and the expiring tick can land on the same clock edge. This is the one case where two of the block's functions compete for the next state.

The bench provokes it by holding `tick_ms` high and firing the trigger exactly P−1 cycles after the restarting write. In Timeout mode and in the open half of a window, the trigger then coincides with the tick at count P−1. The bench judges the outcome by confirming that no reset pulse appears. Vectors one cycle later confirm that the pulse does appear when the trigger comes too late.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CNT_W = 13;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CLOSED,
        ST_OPEN,
        ST_TIMEOUT,
        ST_RESET
    } wd_state_e;

    typedef enum logic [1:0] {
        WM_OFF,
        WM_WINDOW,
        WM_TIMEOUT
    } wd_mode_e;

    localparam logic [2:0] DEFAULT_CODE = 3'b100;

    function automatic logic [CNT_W-1:0] period_ticks(input logic [2:0] code);
        logic [CNT_W-1:0] p;
        case (code)
            3'd6:    p = 13'd1024;
            3'd7:    p = 13'd4096;
            default: p = 13'd8 << code;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    input  logic        restore_code,
    input  logic        off_flag,
    output logic        mode_bit,
    output logic [2:0]  code,
    output logic        locked,
    output logic        wr_ok,
    output logic [15:0] rdata
);

    logic unused_low;
    assign unused_low = ^wdata[7:0];

    assign wr_ok = wr_en && !locked && (wdata[15:13] == 3'b000);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_bit <= 1'b0;
            code     <= DEFAULT_CODE;
            locked   <= 1'b0;
        end else begin
            if (wr_ok) begin
                mode_bit <= wdata[11];
                code     <= wdata[10:8];
                locked   <= wdata[12];
            end
            if (restore_code) begin
                code <= DEFAULT_CODE;
            end
        end
    end

    assign rdata = {3'b000, locked, mode_bit, code, off_flag, 7'b0};

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(mode_bit)));

endmodule

// File: rtl/wdog_mode_sel.sv
module wdog_mode_sel
    import wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     standby,
    input  logic     off_pin,
    input  logic     mode_bit,
    output wd_mode_e eff_mode,
    output logic     mode_chg,
    output logic     off_rise,
    output logic     off_q
);

    wd_mode_e prev_mode;

    always_comb begin
        if (off_pin) begin
            eff_mode = WM_OFF;
        end else if (mode_bit) begin
            eff_mode = standby ? WM_OFF : WM_TIMEOUT;
        end else begin
            eff_mode = standby ? WM_TIMEOUT : WM_WINDOW;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_mode <= WM_WINDOW;
            off_q     <= 1'b0;
        end else begin
            prev_mode <= eff_mode;
            off_q     <= off_pin;
        end
    end

    assign mode_chg = (eff_mode != prev_mode);
    assign off_rise = off_pin && !off_q;

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int RST_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       trig,
    input  logic       restart,
    input  logic       off_rise,
    input  wd_mode_e   eff_mode,
    input  logic [2:0] code,
    output logic       rst_req,
    output logic       pulse_done
);

    localparam logic [CNT_W-1:0] CNT_ONE  = 1;
    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_TICKS - 1);

    wd_state_e        state, st_n, start_st;
    logic [CNT_W-1:0] cnt, cnt_n, per_last, half_last;

    assign per_last  = period_ticks(code) - CNT_ONE;
    assign half_last = (period_ticks(code) >> 1) - CNT_ONE;

    always_comb begin
        unique case (eff_mode)
            WM_WINDOW:  start_st = ST_CLOSED;
            WM_TIMEOUT: start_st = ST_TIMEOUT;
            default:    start_st = ST_OFF;
        endcase
    end

    always_comb begin
        st_n  = state;
        cnt_n = cnt;
        if (state != ST_RESET && off_rise) begin
            st_n  = ST_RESET;
            cnt_n = '0;
        end else if (state != ST_RESET && restart) begin
            st_n  = start_st;
            cnt_n = '0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    st_n = ST_OFF;
                end
                ST_TIMEOUT: begin
                    if (trig) begin
                        cnt_n = '0;
                    end else if (tick) begin
                        if (cnt == per_last) begin
                            st_n  = ST_RESET;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + CNT_ONE;
                        end
                    end
                end
                ST_CLOSED: begin
                    if (trig) begin
                        st_n  = ST_RESET;
                        cnt_n = '0;
                    end else if (tick) begin
                        cnt_n = cnt + CNT_ONE;
                        if (cnt == half_last) begin
                            st_n = ST_OPEN;
                        end
                    end
                end
                ST_OPEN: begin
                    if (trig) begin
                        st_n  = ST_CLOSED;
                        cnt_n = '0;
                    end else if (tick) begin
                        if (cnt == per_last) begin
                            st_n  = ST_RESET;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + CNT_ONE;
                        end
                    end
                end
                ST_RESET: begin
                    if (tick) begin
                        if (cnt == RST_LAST) begin
                            st_n  = start_st;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + CNT_ONE;
                        end
                    end
                end
                default: begin
                    st_n  = ST_OFF;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CLOSED;
            cnt   <= '0;
        end else begin
            state <= st_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        rst_req    = (state == ST_RESET);
        pulse_done = (state == ST_RESET) && tick && (cnt == RST_LAST);
    end

    assert_closed_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLOSED && trig && !restart && !off_rise) |=> rst_req);

    assert_no_tick_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RESET && !tick && !trig && !off_rise) |=> !rst_req);

    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !off_rise && state != ST_RESET) |=> (cnt == '0));

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int RST_TICKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_ms,
    input  logic        trig,
    input  logic        standby,
    input  logic        wd_off_pin,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        rst_req
);

    logic       mode_bit, locked, wr_ok, pulse_done;
    logic       mode_chg, off_rise, off_q;
    logic [2:0] code;
    wd_mode_e   eff_mode;

    wdog_cfg_reg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .wdata        (reg_wdata),
        .restore_code (pulse_done),
        .off_flag     (off_q),
        .mode_bit     (mode_bit),
        .code         (code),
        .locked       (locked),
        .wr_ok        (wr_ok),
        .rdata        (reg_rdata)
    );

    wdog_mode_sel u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .standby  (standby),
        .off_pin  (wd_off_pin),
        .mode_bit (mode_bit),
        .eff_mode (eff_mode),
        .mode_chg (mode_chg),
        .off_rise (off_rise),
        .off_q    (off_q)
    );

    wdog_fsm #(.RST_TICKS(RST_TICKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_ms),
        .trig       (trig),
        .restart    (wr_ok || mode_chg),
        .off_rise   (off_rise),
        .eff_mode   (eff_mode),
        .code       (code),
        .rst_req    (rst_req),
        .pulse_done (pulse_done)
    );

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_off_pin && off_q && !rst_req) |=> !rst_req);

    assert_code_restore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (code == DEFAULT_CODE));

endmodule

// File: tb/wdog_supervisor_bench.sv
module wdog_supervisor_bench;

    logic        clk = 1'b0;
    logic        rst_n, tick_ms, trig, standby, wd_off_pin, reg_wr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        rst_req;
    int          checks = 0, failures = 0;
    bit          seen;

    always #4 clk = ~clk;

    wdog_supervisor u_wdog_supervisor (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_ms    (tick_ms),
        .trig       (trig),
        .standby    (standby),
        .wd_off_pin (wd_off_pin),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .rst_req    (rst_req)
    );

    // {mode, standby, code, cycles before trigger, reset expected}
    localparam logic [21:0] VEC [0:14] = '{
        {1'b0, 1'b0, 3'd0, 16'd3,  1'b1},  // R5 trigger in closed half
        {1'b0, 1'b0, 3'd0, 16'd4,  1'b0},  // R5 first open cycle
        {1'b0, 1'b0, 3'd0, 16'd7,  1'b0},  // R6 window, trigger on expiring tick
        {1'b0, 1'b0, 3'd0, 16'd8,  1'b1},  // R5 window expiry
        {1'b0, 1'b1, 3'd0, 16'd2,  1'b0},  // R3 standby timeout, early trigger fine
        {1'b0, 1'b1, 3'd0, 16'd7,  1'b0},  // R6 timeout, trigger on expiring tick
        {1'b0, 1'b1, 3'd0, 16'd8,  1'b1},  // R4 standby timeout expiry
        {1'b1, 1'b0, 3'd0, 16'd7,  1'b0},  // R3 normal timeout
        {1'b1, 1'b0, 3'd0, 16'd8,  1'b1},  // R4 expiry
        {1'b1, 1'b0, 3'd0, 16'd1,  1'b0},  // R4 early trigger allowed
        {1'b1, 1'b1, 3'd0, 16'd20, 1'b0},  // R3 off in standby
        {1'b1, 1'b0, 3'd1, 16'd15, 1'b0},  // R1 16-tick period
        {1'b1, 1'b0, 3'd1, 16'd16, 1'b1},  // R1 16-tick expiry
        {1'b0, 1'b0, 3'd1, 16'd7,  1'b1},  // R5 closed half of 16
        {1'b0, 1'b0, 3'd1, 16'd8,  1'b0}   // R5 open half of 16
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (rst_req) @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] w);
        reg_wr    = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_ms = 1'b1; trig = 1'b0; standby = 1'b0;
        wd_off_pin = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(reg_rdata == 16'h0400 && !rst_req, "R2 reset word", reg_rdata, 16'h0400);

        // default period 128 in window mode
        repeat (127) @(negedge clk);
        check(rst_req == 1'b0, "R1 default period not yet", rst_req, 0);
        @(negedge clk);
        check(rst_req == 1'b1, "R1 default period expiry", rst_req, 1);
        repeat (3) @(negedge clk);
        check(rst_req == 1'b1, "R8 pulse still high", rst_req, 1);
        @(negedge clk);
        check(rst_req == 1'b0, "R8 pulse ended", rst_req, 0);

        // vector table
        for (int i = 0; i < 15; i++) begin
            wait_idle();
            standby = VEC[i][20];
            write_word({4'b0000, VEC[i][21], VEC[i][19:17], 8'h00});
            seen = 1'b0;
            for (int k = 0; k < int'(VEC[i][16:1]); k++) begin
                @(negedge clk);
                if (rst_req) seen = 1'b1;
            end
            if (!seen) begin
                trig = 1'b1;
                @(negedge clk);
                trig = 1'b0;
                if (rst_req) seen = 1'b1;
            end
            check(seen == VEC[i][0], $sformatf("R3/R4/R5/R6 vector %0d", i), seen, VEC[i][0]);
        end
        standby = 1'b0;

        // R12 no ticks, no progress
        wait_idle();
        tick_ms = 1'b0;
        write_word(16'h0800);
        repeat (50) @(negedge clk);
        check(rst_req == 1'b0, "R12 frozen without tick", rst_req, 0);
        tick_ms = 1'b1;
        repeat (7) @(negedge clk);
        check(rst_req == 1'b0, "R12 seven ticks", rst_req, 0);
        @(negedge clk);
        check(rst_req == 1'b1, "R12 eighth tick expires", rst_req, 1);
        wait_idle();
        check(reg_rdata == 16'h0C00, "R2 code restored after pulse", reg_rdata, 16'h0C00);

        // R1 remaining period codes in timeout mode
        for (int c = 2; c < 8; c++) begin
            int p;
            p = (c < 6) ? (8 << c) : ((c == 6) ? 1024 : 4096);
            wait_idle();
            write_word({5'b00001, 3'(c), 8'h00});
            repeat (p - 1) @(negedge clk);
            check(rst_req == 1'b0, $sformatf("R1 code %0d before end", c), rst_req, 0);
            @(negedge clk);
            check(rst_req == 1'b1, $sformatf("R1 code %0d expiry", c), rst_req, 1);
        end

        // R9 disable pin
        wait_idle();
        write_word(16'h0000);
        wd_off_pin = 1'b1;
        @(negedge clk);
        check(rst_req == 1'b1, "R9 pin rise requests reset", rst_req, 1);
        check(reg_rdata[7] == 1'b1, "R9 off flag set", reg_rdata[7], 1);
        wait_idle();
        seen = 1'b0;
        repeat (200) begin
            @(negedge clk);
            if (rst_req) seen = 1'b1;
        end
        check(seen == 1'b0, "R9 no reset while pin high", seen, 0);
        wd_off_pin = 1'b0;
        @(negedge clk);
        repeat (127) @(negedge clk);
        check(rst_req == 1'b0 && reg_rdata[7] == 1'b0, "R7 restart on pin release", rst_req, 0);
        @(negedge clk);
        check(rst_req == 1'b1, "R7 window 128 after release", rst_req, 1);

        // R11 address filter
        wait_idle();
        write_word(16'h0900);
        write_word(16'h2E00);
        check(reg_rdata == 16'h0900, "R11 nonzero address ignored", reg_rdata, 16'h0900);

        // R10 lock
        write_word(16'h1800);
        write_word(16'h0F00);
        check(reg_rdata == 16'h1800, "R10 locked write ignored", reg_rdata, 16'h1800);

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(reg_rdata == 16'h0400, "R2 reset clears lock", reg_rdata, 16'h0400);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule